// File: doc/BRIEF.md
# Reset Hold Duration Counter

This block measures how long an active-low external reset pin is held low, so that firmware can tell a brief tap from a long press and act on the long one, for example by restoring factory settings. It runs from the 25 MHz reference clock. After a two-flop synchronizer, the count advances once per clock for as long as the pin stays low. The count stops at full scale rather than wrapping. When the pin is released, the count keeps its value.

Software reads the measured length from a 32-bit register view. Software clears it by writing a 1 to bit 31. A comparator turns the stored count into a sticky long-press flag. The flag sets once the count reaches a programmable number of seconds, where one second is `TICKS_PER_SEC` counts (25,000,000 by default). A threshold of zero switches the comparator off.

With the default 29-bit count, the longest press that can be measured is 2^29 / 25 MHz, about 21.4 seconds.

Top module: `rhc_hold_timer`

## Requirements
- R1: The pin passes through a two-flop synchronizer. The first increment lands on the third rising clock edge after the pin goes low. A low period of L clock cycles adds exactly L to the count.
- R2: While the synchronized pin is low, the count rises by exactly one per clock cycle.
- R3: The count saturates at 2^CNT_W-1 (CNT_W = 29 by default) and stays there while the pin remains low. It never wraps to zero.
- R4: While the synchronized pin is high and no clear is written, the count does not change.
- R5: The read view `rd_data_o` carries the count in bits CNT_W-1:0. Every bit above that, including bit 31, reads as zero.
- R6: A write with bit 31 set clears the count and the long-press flag on the next clock edge. In that cycle the clear takes priority over counting. A write with bit 31 clear has no effect on the count or the flag.
- R7: When `thresh_sec_i` is nonzero, `long_press_o` sets one cycle after the count first satisfies count >= TICKS_PER_SEC * thresh_sec_i.
- R8: `long_press_o` stays set until a clear. A threshold of zero never sets it.
- R9: A new low period that starts with a nonzero stored count continues counting from the stored value.
- R10: After reset the count is zero, `long_press_o` is low, and the pin is treated as released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 25 MHz reference clock |
| rst_ni | input | 1 | Block asynchronous reset, active low |
| ext_rst_n_i | input | 1 | Measured external reset pin, active low, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Write data; bit 31 = 1 requests a clear |
| thresh_sec_i | input | TH_W | Long-press threshold in seconds, 0 disables |
| rd_data_o | output | 32 | Read view: count in low CNT_W bits, zeros above |
| long_press_o | output | 1 | Sticky long-press flag |

## Verification
The bench uses a small instance (8-bit count, 10 counts per second) so that saturation and the threshold can be reached in a few hundred cycles. Single presses of known length check the exact count, including the synchronizer's symmetric delay. Back-to-back presses separate accumulation from restarting at zero. A press longer than full scale separates saturation from wrapping. A count parked at the threshold minus one, then advanced by a single-cycle press, pins down the comparator's inclusive edge. A clear written in the middle of a press shows that the clear wins over counting and that counting then resumes. Writes with bit 31 low, and a zero threshold, are checked for having no effect.

// File: rtl/rhc_pkg.sv
package rhc_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned CLR_BIT = 31;

  function automatic int unsigned max_w(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rhc_sync.sv
module rhc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  // reset to 1: pin treated as released
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/rhc_counter.sv
module rhc_counter #(
  parameter int unsigned CNT_W = 29
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (run_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rhc_compare.sv
module rhc_compare
  import rhc_pkg::*;
#(
  parameter int unsigned CNT_W         = 29,
  parameter int unsigned TH_W          = 8,
  parameter int unsigned TICKS_PER_SEC = 25_000_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [TH_W-1:0]  thresh_sec_i,
  input  logic             clr_i,
  output logic             flag_o
);
  localparam int unsigned TPS_W  = $clog2(TICKS_PER_SEC + 1);
  localparam int unsigned PROD_W = TPS_W + TH_W;
  localparam int unsigned CMP_W  = max_w(PROD_W, CNT_W) + 1;

  logic [CMP_W-1:0] limit;
  logic             hit;
  logic             flag_q;

  assign limit = CMP_W'(TICKS_PER_SEC) * CMP_W'(thresh_sec_i);
  assign hit   = (thresh_sec_i != '0) && (CMP_W'(cnt_i) >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (clr_i) flag_q <= 1'b0;
    else if (hit)   flag_q <= 1'b1;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/rhc_hold_timer.sv
module rhc_hold_timer
  import rhc_pkg::*;
#(
  parameter int unsigned CNT_W         = 29,
  parameter int unsigned TH_W          = 8,
  parameter int unsigned TICKS_PER_SEC = 25_000_000,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_rst_n_i,
  input  logic             wr_en_i,
  input  logic [31:0]      wr_data_i,
  input  logic [TH_W-1:0]  thresh_sec_i,
  output logic [31:0]      rd_data_o,
  output logic             long_press_o
);
  logic             pin_sync;
  logic             held;
  logic             clr_req;
  logic [CNT_W-1:0] cnt_q;

  rhc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ext_rst_n_i),
    .q_o   (pin_sync)
  );

  assign held    = ~pin_sync;
  assign clr_req = wr_en_i & wr_data_i[CLR_BIT];

  rhc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (held),
    .clr_i (clr_req),
    .cnt_o (cnt_q)
  );

  rhc_compare #(
    .CNT_W        (CNT_W),
    .TH_W         (TH_W),
    .TICKS_PER_SEC(TICKS_PER_SEC)
  ) u_cmp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cnt_i       (cnt_q),
    .thresh_sec_i(thresh_sec_i),
    .clr_i       (clr_req),
    .flag_o      (long_press_o)
  );

  assign rd_data_o = REG_W'(cnt_q);
endmodule

// File: rtl/rhc_hold_timer_chk.sv
module rhc_hold_timer_chk #(
  parameter int unsigned CNT_W = 29
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             held,
  input logic             clr_req,
  input logic [CNT_W-1:0] cnt_q,
  input logic [31:0]      rd_data_o,
  input logic             long_press_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R2
  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held && !clr_req && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);

  // R3
  a_r3_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !clr_req) |=> cnt_q == CNT_MAX);

  // R4
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!held && !clr_req) |=> $stable(cnt_q));

  // R5
  a_r5_top_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[31] == 1'b0);

  // R6
  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_req |=> (cnt_q == '0 && !long_press_o));

  // R8
  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (long_press_o && !clr_req) |=> long_press_o);
endmodule

bind rhc_hold_timer rhc_hold_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .held        (held),
  .clr_req     (clr_req),
  .cnt_q       (cnt_q),
  .rd_data_o   (rd_data_o),
  .long_press_o(long_press_o)
);

// File: tb/rhc_hold_timer_tb_top.sv
`timescale 1ns/1ps
module rhc_hold_timer_tb_top;
  localparam int unsigned CNT_W = 8;
  localparam int unsigned TH_W  = 4;
  localparam int unsigned TPS   = 10;
  localparam int unsigned FULL  = (1 << CNT_W) - 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            pin_n = 1'b1;
  logic            wr_en = 1'b0;
  logic [31:0]     wr_data = '0;
  logic [TH_W-1:0] thr = '0;
  logic [31:0]     rd_data;
  logic            lp;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rhc_hold_timer #(
    .CNT_W(CNT_W), .TH_W(TH_W), .TICKS_PER_SEC(TPS)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ext_rst_n_i(pin_n),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .thresh_sec_i(thr),
    .rd_data_o(rd_data), .long_press_o(lp)
  );

  task automatic chk32(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic press(int n);
    @(negedge clk) pin_n = 1'b0;
    repeat (n) @(negedge clk);
    pin_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic write(logic [31:0] d);
    @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
    @(negedge clk) begin wr_en = 1'b0; wr_data = '0; end
  endtask

  task automatic t_reset();
    chk32("R10 count", rd_data, 0);
    chk32("R10 flag", {31'd0, lp}, 0);
  endtask

  task automatic t_basic();
    press(5);
    chk32("R1 R2 press 5", rd_data, 5);
    press(3);
    chk32("R9 accumulate", rd_data, 8);
    repeat (10) @(negedge clk);
    chk32("R4 hold after release", rd_data, 8);
    write(32'h7FFF_FFFF);
    chk32("R6 write bit31=0 no effect", rd_data, 8);
    write(32'h8000_0000);
    chk32("R6 clear count", rd_data, 0);
  endtask

  task automatic t_saturate();
    press(300);
    chk32("R3 saturate", rd_data, FULL);
    chk32("R5 upper bits zero", rd_data & ~32'(FULL), 0);
    chk32("R8 zero threshold no flag", {31'd0, lp}, 0);
    write(32'h8000_0000);
    chk32("R6 clear after saturation", rd_data, 0);
  endtask

  task automatic t_threshold();
    thr = 4'd2;
    press(19);
    chk32("R7 below limit count", rd_data, 19);
    chk32("R7 below limit flag", {31'd0, lp}, 0);
    press(1);
    chk32("R7 at limit count", rd_data, 20);
    chk32("R7 at limit flag", {31'd0, lp}, 1);
    repeat (5) @(negedge clk);
    chk32("R8 flag sticky", {31'd0, lp}, 1);
    write(32'h0000_0001);
    chk32("R6 non-clear write keeps flag", {31'd0, lp}, 1);
    write(32'h8000_0000);
    chk32("R6 clear flag", {31'd0, lp}, 0);
    chk32("R6 clear count with flag", rd_data, 0);
    thr = 4'd0;
  endtask

  task automatic t_mid_clear();
    @(negedge clk) pin_n = 1'b0;
    repeat (10) @(posedge clk);
    @(negedge clk) begin wr_en = 1'b1; wr_data = 32'h8000_0000; end
    @(negedge clk) begin wr_en = 1'b0; wr_data = '0; end
    repeat (9) @(negedge clk);
    pin_n = 1'b1;
    repeat (4) @(negedge clk);
    chk32("R6 clear beats count mid press", rd_data, 11);
    write(32'h8000_0000);
    press(30);
    chk32("R2 press 30", rd_data, 30);
    chk32("R8 zero threshold press 30", {31'd0, lp}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_saturate();
    t_threshold();
    t_mid_clear();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule